// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block models the device side of a 16,384-bit serial EEPROM that a host drives through a select line, a serial clock, a data-in line and a tristatable data-out line. It can present the array either as 1024 words of 16 bits or as 2048 bytes. A mode input picks the width. The block decodes each frame bit by bit. It serves single and streaming reads, and it runs a self-timed program cycle. The host polls that cycle for completion on the data-out line.

All pins are sampled by a fast system clock, and serial clock edges are found by comparing each sample with the previous one. Programming needs two things: a software write-enable latch, and a program-enable pin that is high when the select line drops. The nonvolatile array is modelled as a register array, and the program time is a parameter counted in system clock cycles.

Top module: `mw_eeprom`

## Requirements
- R1: A frame is a 1 start bit, then a 2-bit opcode, then the address MSB first (10 bits when byte_mode=0, 11 bits when byte_mode=1), then 16 or 8 data bits for the write forms. Zeros ahead of the start bit are ignored and sdin is taken on rising sclk. Opcodes: 10 read, 01 write, 11 erase, 00 extended. In an extended frame the two top address bits select 11 enable, 00 disable, 10 erase-all or 01 write-all.
- R2: sdout_en is low after reset, and within one cycle of sel going low. It is high only during read output or busy polling.
- R3: On the rising sclk that carries the last address bit of a read, sdout_en rises and sdout drives a dummy 0. The word then follows MSB first, one bit per later rising sclk.
- R4: While sel stays high, a read continues with the next address and no further dummy bit, and it wraps from the last address to 0.
- R5: A write starts when sel falls after a complete frame. It replaces the word with no prior erase, and it keeps the device busy for WRITE_CYCLES clock cycles.
- R6: If sel rises while the device is busy, sdout_en goes high. sdout shows 0 while busy and 1 once ready.
- R7: While polling, a 1 taken on sdin returns sdout_en low after the next falling sclk.
- R8: Write, erase, erase-all and write-all have no effect unless the enable latch is set. The latch is clear after reset, is set by enable and is cleared by disable, and both enable and disable ignore prog_en.
- R9: Write, erase, erase-all and write-all have no effect, and start no busy period, unless prog_en is high when sel falls.
- R10: Erase sets the addressed location to all ones. Erase-all sets every location to all ones, and write-all writes the data to every location.
- R11: With byte_mode=1, byte address b maps to word b>>1, taking the upper half when b is odd and the lower half when b is even.
- R12: Frames sent while a write cycle is running are ignored.
- R13: Dropping sel in the middle of a frame discards it, and the next frame decodes from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data in |
| prog_en | input | 1 | Program enable for modifying frames |
| byte_mode | input | 1 | 1 selects 2048x8, 0 selects 1024x16 |
| sdout | output | 1 | Serial data out |
| sdout_en | output | 1 | Output enable for sdout |

## Verification
The hardest situation to reach is a frame that arrives while a program cycle is still running. It has to line up with the polling logic, and it must not turn into a spurious start bit once the cycle ends. The bench gets there by making the program time longer than one full write frame. It sends a second complete write frame right after the first one drops sel, then reads the location back to confirm that only the first data landed. A separate sequence raises sel while the device is busy and samples the status bit before and after the timer expires. It then clocks in a 1 and confirms that the output releases on the following falling clock.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_WAIT
    } mw_state_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_WORD,
        PEND_ALL
    } mw_pend_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_DIS   = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_EN    = 2'b11;
endpackage

// File: rtl/mw_pin_edges.sv
module mw_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sel,
    output logic sk_rise,
    output logic sk_fall,
    output logic sel_rise,
    output logic sel_fall
);
    logic sclk_d, sclk_q;
    logic sel_d, sel_q;

    always_comb begin
        sclk_d = sclk;
        sel_d  = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_d;
            sel_q  <= sel_d;
        end
    end

    assign sk_rise  = sclk & ~sclk_q;
    assign sk_fall  = ~sclk & sclk_q;
    assign sel_rise = sel & ~sel_q;
    assign sel_fall = ~sel & sel_q;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_mask,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_all || (ADDR_W'(i) == wr_addr)) begin
                    if (wr_mask[0]) mem_q[i][BYTE_W-1:0]      <= wr_data[BYTE_W-1:0];
                    if (wr_mask[1]) mem_q[i][WORD_W-1:BYTE_W] <= wr_data[WORD_W-1:BYTE_W];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R12
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R5
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int WORD_W       = 16,
    parameter int WRITE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdin,
    input  logic prog_en,
    input  logic byte_mode,
    output logic sdout,
    output logic sdout_en
);
    localparam int BYTE_W  = WORD_W / 2;
    localparam int BADDR_W = ADDR_W + 1;
    localparam int SH_W    = 2 + BADDR_W;
    localparam int CNT_W   = $clog2(SH_W + WORD_W + 1);
    localparam int BIDX_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  LAST_CMD_W = CNT_W'(2 + ADDR_W - 1);
    localparam logic [CNT_W-1:0]  LAST_CMD_B = CNT_W'(2 + BADDR_W - 1);
    localparam logic [CNT_W-1:0]  LAST_DAT_W = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0]  LAST_DAT_B = CNT_W'(BYTE_W - 1);
    localparam logic [BIDX_W-1:0] TOP_BIT_W  = BIDX_W'(WORD_W - 1);
    localparam logic [BIDX_W-1:0] TOP_BIT_B  = BIDX_W'(BYTE_W - 1);

    typedef struct packed {
        mw_state_e          st;
        logic [SH_W-1:0]    sh;
        logic [CNT_W-1:0]   cnt;
        logic               wen;
        mw_pend_e           pend;
        logic [BADDR_W-1:0] paddr;
        logic [WORD_W-1:0]  pdata;
        logic [BADDR_W-1:0] raddr;
        logic [BIDX_W-1:0]  bidx;
        logic               dout;
        logic               oe;
        logic               poll;
        logic               poll_arm;
    } ctl_t;

    ctl_t r, n;

    logic sk_rise, sk_fall, sel_rise, sel_fall;
    logic busy, wr_start;
    logic [WORD_W-1:0] rd_data, rd_view;
    logic [ADDR_W-1:0] rd_word, wr_word;
    logic [1:0]        wr_mask;
    logic [WORD_W-1:0] wr_data;

    mw_pin_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .sel      (sel),
        .sk_rise  (sk_rise),
        .sk_fall  (sk_fall),
        .sel_rise (sel_rise),
        .sel_fall (sel_fall)
    );

    mw_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_start),
        .busy  (busy)
    );

    // Word index and byte view for the streaming read pointer
    assign rd_word = byte_mode ? r.raddr[BADDR_W-1:1] : r.raddr[ADDR_W-1:0];
    assign rd_view = byte_mode
        ? {{BYTE_W{1'b0}}, (r.raddr[0] ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0])}
        : rd_data;

    // Write port derived from the pending operation
    assign wr_word = byte_mode ? r.paddr[BADDR_W-1:1] : r.paddr[ADDR_W-1:0];
    assign wr_data = byte_mode ? {2{r.pdata[BYTE_W-1:0]}} : r.pdata;
    assign wr_mask = (!byte_mode || r.pend == PEND_ALL) ? 2'b11
                   : (r.paddr[0] ? 2'b10 : 2'b01);

    mw_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_start),
        .wr_all  (r.pend == PEND_ALL),
        .wr_addr (wr_word),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_addr (rd_word),
        .rd_data (rd_data)
    );

    always_comb begin
        logic [SH_W-1:0]    sh_nx;
        logic [1:0]         op;
        logic [1:0]         ext;
        logic [BADDR_W-1:0] addr_nx;
        logic [CNT_W-1:0]   last_cmd;
        logic [CNT_W-1:0]   last_dat;
        logic [BIDX_W-1:0]  top_bit;

        n        = r;
        wr_start = 1'b0;

        sh_nx    = {r.sh[SH_W-2:0], sdin};
        op       = byte_mode ? sh_nx[SH_W-1 -: 2] : sh_nx[SH_W-2 -: 2];
        ext      = byte_mode ? sh_nx[BADDR_W-1 -: 2] : sh_nx[ADDR_W-1 -: 2];
        addr_nx  = byte_mode ? sh_nx[BADDR_W-1:0] : {1'b0, sh_nx[ADDR_W-1:0]};
        last_cmd = byte_mode ? LAST_CMD_B : LAST_CMD_W;
        last_dat = byte_mode ? LAST_DAT_B : LAST_DAT_W;
        top_bit  = byte_mode ? TOP_BIT_B : TOP_BIT_W;

        if (sel_fall) begin
            if (r.st == ST_WAIT && r.pend != PEND_NONE && prog_en && !busy)
                wr_start = 1'b1;
            n.st       = ST_IDLE;
            n.cnt      = '0;
            n.pend     = PEND_NONE;
            n.oe       = 1'b0;
            n.dout     = 1'b0;
            n.poll     = 1'b0;
            n.poll_arm = 1'b0;
        end else if (sel) begin
            if (sel_rise) begin
                n.poll     = busy;
                n.poll_arm = 1'b0;
            end
            if (sk_rise) begin
                if (r.poll && sdin) n.poll_arm = 1'b1;
                unique case (r.st)
                    ST_IDLE: begin
                        if (sdin && !busy) begin
                            n.st  = ST_CMD;
                            n.cnt = '0;
                            n.sh  = '0;
                        end
                    end
                    ST_CMD: begin
                        n.sh  = sh_nx;
                        n.cnt = r.cnt + 1'b1;
                        if (r.cnt == last_cmd) begin
                            n.cnt   = '0;
                            n.paddr = addr_nx;
                            unique case (op)
                                OP_READ: begin
                                    n.st    = ST_READ;
                                    n.raddr = addr_nx;
                                    n.bidx  = top_bit;
                                    n.oe    = 1'b1;
                                    n.dout  = 1'b0;
                                end
                                OP_WRITE: begin
                                    n.st   = ST_DATA;
                                    n.pend = r.wen ? PEND_WORD : PEND_NONE;
                                end
                                OP_ERASE: begin
                                    n.st    = ST_WAIT;
                                    n.pdata = '1;
                                    n.pend  = r.wen ? PEND_WORD : PEND_NONE;
                                end
                                default: begin
                                    n.st = ST_WAIT;
                                    unique case (ext)
                                        EXT_EN:  n.wen = 1'b1;
                                        EXT_DIS: n.wen = 1'b0;
                                        EXT_ERALL: begin
                                            n.pdata = '1;
                                            n.pend  = r.wen ? PEND_ALL : PEND_NONE;
                                        end
                                        default: begin
                                            n.st   = ST_DATA;
                                            n.pend = r.wen ? PEND_ALL : PEND_NONE;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        n.pdata = {r.pdata[WORD_W-2:0], sdin};
                        n.cnt   = r.cnt + 1'b1;
                        if (r.cnt == last_dat) n.st = ST_WAIT;
                    end
                    ST_READ: begin
                        n.dout = rd_view[r.bidx];
                        if (r.bidx == '0) begin
                            n.bidx  = top_bit;
                            n.raddr = byte_mode ? r.raddr + 1'b1
                                                : {1'b0, r.raddr[ADDR_W-1:0] + 1'b1};
                        end else begin
                            n.bidx = r.bidx - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (sk_fall && r.poll_arm) begin
                n.poll     = 1'b0;
                n.poll_arm = 1'b0;
            end
            if (n.poll) begin
                n.oe   = 1'b1;
                n.dout = !busy;
            end else if (n.st != ST_READ) begin
                n.oe   = 1'b0;
                n.dout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r.st       <= ST_IDLE;
            r.sh       <= '0;
            r.cnt      <= '0;
            r.wen      <= 1'b0;
            r.pend     <= PEND_NONE;
            r.paddr    <= '0;
            r.pdata    <= '0;
            r.raddr    <= '0;
            r.bidx     <= '0;
            r.dout     <= 1'b0;
            r.oe       <= 1'b0;
            r.poll     <= 1'b0;
            r.poll_arm <= 1'b0;
        end else begin
            r <= n;
        end
    end

    assign sdout    = r.dout;
    assign sdout_en = r.oe;

    // R2
    sdout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdout_en);

    // R3
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r.st == ST_READ) |-> sdout_en);

    // R8
    write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> r.wen);

    // R9
    write_needs_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> prog_en);
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
    localparam int WC = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, prog_en = 1'b1, byte_mode = 1'b0;
    logic sdout, sdout_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mw_eeprom #(.WRITE_CYCLES(WC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk      (sclk),
        .sdin      (sdin),
        .prog_en   (prog_en),
        .byte_mode (byte_mode),
        .sdout     (sdout),
        .sdout_en  (sdout_en)
    );

    // {byte_mode, address, data}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 11'd5,    16'hA5C3},
        {1'b0, 11'd0,    16'h1234},
        {1'b0, 11'd1023, 16'h8001},
        {1'b0, 11'd512,  16'h0F0F},
        {1'b1, 11'd20,   16'h003C},
        {1'b1, 11'd21,   16'h00E7},
        {1'b1, 11'd2047, 16'h0081},
        {1'b1, 11'd0,    16'h005A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic sk_bit_s(input logic b, output logic o, output logic oe);
        sdin = b;
        tick(1);
        sclk = 1'b1;
        tick(3);
        o  = sdout;
        oe = sdout_en;
        sclk = 1'b0;
        tick(3);
    endtask

    task automatic sk_bit(input logic b);
        logic o, oe;
        sk_bit_s(b, o, oe);
    endtask

    task automatic send_frame(input logic bm, input logic [1:0] op, input logic [10:0] a,
                              output logic lo, output logic loe);
        int ab = bm ? 11 : 10;
        sk_bit(1'b1);
        sk_bit(op[1]);
        sk_bit(op[0]);
        for (int i = ab - 1; i >= 0; i--) sk_bit_s(a[i], lo, loe);
    endtask

    task automatic mod_cmd(input logic bm, input logic [1:0] op, input logic [10:0] a,
                           input bit has_data, input logic [15:0] d, input bit wait_done);
        logic lo, loe;
        int db = bm ? 8 : 16;
        sel = 1'b1;
        tick(2);
        send_frame(bm, op, a, lo, loe);
        if (has_data) for (int i = db - 1; i >= 0; i--) sk_bit(d[i]);
        sel = 1'b0;
        tick(2);
        if (wait_done) tick(WC + 10);
    endtask

    task automatic ext_cmd(input logic bm, input logic [1:0] code, input logic [15:0] d,
                           input bit wait_done);
        logic [10:0] a = bm ? {code, 9'd0} : {1'b0, code, 8'd0};
        mod_cmd(bm, 2'b00, a, (code == 2'b01), d, wait_done);
    endtask

    task automatic read_words(input logic bm, input logic [10:0] a, input int nw, input int lead,
                              output logic [63:0] rbuf, output logic dum, output logic dum_oe);
        logic o, oe;
        int db = bm ? 8 : 16;
        rbuf = '0;
        sel = 1'b1;
        tick(2);
        for (int i = 0; i < lead; i++) sk_bit(1'b0);
        send_frame(bm, 2'b10, a, dum, dum_oe);
        for (int w = 0; w < nw; w++)
            for (int b = 0; b < db; b++) begin
                sk_bit_s(1'b0, o, oe);
                rbuf = {rbuf[62:0], o};
            end
        sel = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] rb;
        logic dm, dmoe, o, oe;
        tick(3);
        chk("R2 reset oe", {31'd0, sdout_en}, 32'd0);
        rst_n = 1'b1;
        tick(3);

        // Table walk: enable, write, read back (R1, R3, R5, R11)
        for (int i = 0; i < 8; i++) begin
            logic        bm;
            logic [10:0] a;
            logic [15:0] d;
            {bm, a, d} = VEC[i];
            byte_mode = bm;
            ext_cmd(bm, 2'b11, 16'h0, 1'b0);
            mod_cmd(bm, 2'b01, a, 1'b1, d, 1'b1);
            read_words(bm, a, 1, 0, rb, dm, dmoe);
            chk("R1 table read", {16'd0, rb[15:0]}, bm ? {24'd0, d[7:0]} : {16'd0, d});
            chk("R3 dummy zero", {30'd0, dm, dmoe}, 32'd1);
            chk("R2 released", {31'd0, sdout_en}, 32'd0);
        end

        // R11 byte mapping seen as a word
        byte_mode = 1'b0;
        read_words(1'b0, 11'd10, 1, 0, rb, dm, dmoe);
        chk("R11 bytes 20/21", {16'd0, rb[15:0]}, 32'h0000E73C);

        // R4 sequential read with wrap
        read_words(1'b0, 11'd1023, 2, 0, rb, dm, dmoe);
        chk("R4 wrap x16", rb[31:0], 32'h8101125A);
        byte_mode = 1'b1;
        read_words(1'b1, 11'd2047, 2, 0, rb, dm, dmoe);
        chk("R4 wrap x8", {16'd0, rb[15:0]}, 32'h0000815A);
        read_words(1'b1, 11'd20, 2, 2, rb, dm, dmoe);
        chk("R1 leading zeros seq", {16'd0, rb[15:0]}, 32'h00003CE7);
        byte_mode = 1'b0;

        // R5 overwrite without erase
        mod_cmd(1'b0, 2'b01, 11'd5, 1'b1, 16'h5A5A, 1'b1);
        read_words(1'b0, 11'd5, 1, 0, rb, dm, dmoe);
        chk("R5 overwrite", {16'd0, rb[15:0]}, 32'h00005A5A);

        // R6 / R7 busy polling
        mod_cmd(1'b0, 2'b01, 11'd7, 1'b1, 16'h7777, 1'b0);
        sel = 1'b1;
        tick(2);
        chk("R6 busy poll", {30'd0, sdout_en, sdout}, 32'd2);
        tick(WC - 40);
        chk("R5 still busy", {30'd0, sdout_en, sdout}, 32'd2);
        tick(50);
        chk("R6 ready poll", {30'd0, sdout_en, sdout}, 32'd3);
        sk_bit_s(1'b1, o, oe);
        chk("R7 held until fall", {31'd0, oe}, 32'd1);
        chk("R7 released", {31'd0, sdout_en}, 32'd0);
        sel = 1'b0;
        tick(2);

        // R12 frame during busy is ignored
        mod_cmd(1'b0, 2'b01, 11'd8, 1'b1, 16'h1111, 1'b0);
        mod_cmd(1'b0, 2'b01, 11'd8, 1'b1, 16'h2222, 1'b0);
        tick(WC + 10);
        read_words(1'b0, 11'd8, 1, 0, rb, dm, dmoe);
        chk("R12 busy ignore", {16'd0, rb[15:0]}, 32'h00001111);

        // R13 abort partial frame
        sel = 1'b1;
        tick(2);
        sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1);
        for (int i = 0; i < 5; i++) sk_bit(1'b1);
        sel = 1'b0;
        tick(2);
        read_words(1'b0, 11'd7, 1, 0, rb, dm, dmoe);
        chk("R13 abort", {16'd0, rb[15:0]}, 32'h00007777);

        // R8 enable latch
        ext_cmd(1'b0, 2'b00, 16'h0, 1'b0);
        mod_cmd(1'b0, 2'b01, 11'd9, 1'b1, 16'h9999, 1'b1);
        read_words(1'b0, 11'd9, 1, 0, rb, dm, dmoe);
        chk("R8 disabled write", {16'd0, rb[15:0]}, 32'h0000FFFF);
        prog_en = 1'b0;
        ext_cmd(1'b0, 2'b11, 16'h0, 1'b0);
        prog_en = 1'b1;
        mod_cmd(1'b0, 2'b01, 11'd9, 1'b1, 16'h9999, 1'b1);
        read_words(1'b0, 11'd9, 1, 0, rb, dm, dmoe);
        chk("R8 enable ignores PE", {16'd0, rb[15:0]}, 32'h00009999);

        // R9 program enable pin
        prog_en = 1'b0;
        mod_cmd(1'b0, 2'b01, 11'd11, 1'b1, 16'hABCD, 1'b0);
        sel = 1'b1;
        tick(2);
        chk("R9 no busy", {31'd0, sdout_en}, 32'd0);
        sel = 1'b0;
        tick(2);
        prog_en = 1'b1;
        read_words(1'b0, 11'd11, 1, 0, rb, dm, dmoe);
        chk("R9 blocked write", {16'd0, rb[15:0]}, 32'h0000FFFF);

        // R10 erase forms and write-all
        mod_cmd(1'b0, 2'b11, 11'd5, 1'b0, 16'h0, 1'b1);
        read_words(1'b0, 11'd5, 1, 0, rb, dm, dmoe);
        chk("R10 erase", {16'd0, rb[15:0]}, 32'h0000FFFF);
        ext_cmd(1'b0, 2'b01, 16'h3C3C, 1'b1);
        read_words(1'b0, 11'd1023, 2, 0, rb, dm, dmoe);
        chk("R10 write-all x16", rb[31:0], 32'h3C3C3C3C);
        byte_mode = 1'b1;
        ext_cmd(1'b1, 2'b01, 16'h0096, 1'b1);
        byte_mode = 1'b0;
        read_words(1'b0, 11'd300, 1, 0, rb, dm, dmoe);
        chk("R10 write-all x8", {16'd0, rb[15:0]}, 32'h00009696);
        ext_cmd(1'b0, 2'b10, 16'h0, 1'b1);
        read_words(1'b0, 11'd1023, 2, 0, rb, dm, dmoe);
        chk("R10 erase-all", rb[31:0], 32'hFFFFFFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule